// File: doc/BRIEF.md
# CAN Transmit Buffer Priority Arbiter

This block decides which of three transmit message slots the transmit engine sends next. Each slot has a pending flag, set by a one-cycle request pulse, and a 2-bit priority. The priority arrives as a static configuration input. When the transmit engine signals that it is about to send the start-of-frame bit, the arbiter compares the priorities of every pending slot and latches one winner. A higher priority value wins. When priorities are equal, the slot with the larger number wins.

The latched grant is then frozen for the whole frame. The engine ends the frame with one of two pulses. A completion pulse retires the granted slot. A lost-arbitration pulse leaves the slot pending, so it takes part in the next selection. Request or priority changes made during a frame only affect the selection made at the next start-of-frame point.

Top module: `can_txq_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, all pending flags clear, `grant_valid` goes to 0 and `grant_idx` goes to 0. This also applies in the middle of a frame.
- R2: A `req_set[i]` pulse makes `req_pending[i]` read 1 from the next cycle on. Selection uses only flags already registered, so a request raised in the same cycle as `sof_ready` is not granted in that cycle.
- R3: When `sof_ready` is high, no grant is held and at least one flag is pending, the next cycle shows `grant_valid`=1. `grant_idx` then names the pending slot with the largest priority. Slot i's priority is `prio_flat[2i+1:2i]`, and 3 is the highest value.
- R4: When several pending slots share the largest priority, the one with the highest index is granted.
- R5: `sof_ready` with no pending flag leaves `grant_valid` at 0.
- R6: While `grant_valid` is 1 and neither end pulse is present, `grant_idx` and `grant_valid` hold. This is true whatever happens on `prio_flat`, `req_set` or `sof_ready`.
- R7: `frame_done` while granted drops `grant_valid` in the next cycle and clears only the granted slot's flag.
- R8: `arb_lost` while granted drops `grant_valid` in the next cycle and keeps the granted slot's flag set. The next `sof_ready` then performs a fresh selection with the current priorities.
- R9: A `req_set` for the granted slot in the same cycle as `frame_done` leaves that slot pending.
- R10: `frame_done` or `arb_lost` while no grant is held changes neither the flags nor `grant_valid`.
- R11: If `frame_done` and `arb_lost` arrive together, the completion wins and the granted flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_set | input | 3 | One pulse per slot; sets that slot's pending flag |
| prio_flat | input | 6 | Packed 2-bit priorities; slot i at bits [2i+1:2i] |
| sof_ready | input | 1 | The engine is about to send start-of-frame; sample the selection now |
| frame_done | input | 1 | The granted frame completed |
| arb_lost | input | 1 | The granted frame lost bus arbitration |
| grant_valid | output | 1 | A slot is granted for the current frame |
| grant_idx | output | 2 | Index of the granted slot |
| req_pending | output | 3 | Pending flag of each slot |

## Verification
The assertions assume that the transmit engine raises `frame_done` and `arb_lost` only while a grant is held. They also assume that a frame always ends with one of those two pulses before the next start-of-frame sample. The bench respects this in its table walk. In the directed tests it issues stray end pulses only while idle, to show that they are ignored. Priorities and request pulses are driven freely during a frame, because the design is required to tolerate them there.

// File: rtl/can_txq_pkg.sv
// Package: shared types for the transmit slot arbiter.
// Assumes: nothing beyond the standard language.
package can_txq_pkg;

    // Grant controller state: waiting for a start-of-frame sample, or holding a grant.
    typedef enum logic {
        TXQ_IDLE = 1'b0,
        TXQ_BUSY = 1'b1
    } txq_state_e;

endpackage

// File: rtl/can_txq_req_flags.sv
// Module: bank of per-slot pending flags.
// What it does: a set pulse raises a flag, a clear pulse lowers it, and set wins when both arrive together.
// Assumes: at most one clear bit is active per cycle (it comes from a one-hot decode).
module can_txq_req_flags #(
    parameter int NUM_BUF = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BUF-1:0] set_vec,
    input  logic [NUM_BUF-1:0] clr_vec,
    output logic [NUM_BUF-1:0] flags
);

    for (genvar i = 0; i < NUM_BUF; i++) begin : g_flag
        // Purpose: hold one slot's pending flag; set has precedence over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (set_vec[i])
                flags[i] <= 1'b1;
            else if (clr_vec[i])
                flags[i] <= 1'b0;
        end

        // A set pulse is visible in the next cycle (R2, R9).
        assert_set_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> flags[i]);

        // A clear without a set retires the flag (R7).
        assert_clear_retires_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[i] && !set_vec[i]) |=> !flags[i]);

        // With no set and no clear the flag holds (R10).
        assert_flag_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_vec[i] && !set_vec[i]) |=> $stable(flags[i]));
    end

endmodule

// File: rtl/can_txq_select.sv
// Module: combinational winner search over the pending slots.
// What it does: finds the pending slot with the largest priority; on a tie the higher index wins.
// Assumes: priorities are packed PRIO_W bits per slot, slot 0 in the low bits. clk and rst_n feed the checks only.
module can_txq_select #(
    parameter int NUM_BUF = 3,
    parameter int PRIO_W  = 2,
    localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_BUF-1:0]        req,
    input  logic [NUM_BUF*PRIO_W-1:0] prio_flat,
    output logic                      sel_any,
    output logic [IDX_W-1:0]          sel_idx
);

    logic [PRIO_W-1:0] best_prio;

    // Purpose: scan upwards; ">=" lets a later, equal-priority slot take over.
    always_comb begin
        sel_any   = 1'b0;
        sel_idx   = '0;
        best_prio = '0;
        for (int i = 0; i < NUM_BUF; i++) begin
            if (req[i] && (!sel_any || prio_flat[i*PRIO_W +: PRIO_W] >= best_prio)) begin
                sel_any   = 1'b1;
                sel_idx   = IDX_W'(i);
                best_prio = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end

    // The chosen slot must be pending (R3).
    assert_pick_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_any |-> req[sel_idx]);

    for (genvar j = 0; j < NUM_BUF; j++) begin : g_chk
        // No pending slot beats the winner (R3).
        assert_no_better_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_any && req[j]) |-> (prio_flat[j*PRIO_W +: PRIO_W] <= best_prio));
        // A higher-indexed pending slot never ties the winner (R4).
        assert_tie_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_any && req[j] && (IDX_W'(j) > sel_idx)) |->
            (prio_flat[j*PRIO_W +: PRIO_W] < best_prio));
    end

endmodule

// File: rtl/can_txq_grant_ctrl.sv
// Module: grant latch and frame-end handling.
// What it does: samples the winner at the start-of-frame point, freezes it until a frame-end pulse,
//   and on completion raises a one-hot clear for the granted slot.
// Assumes: frame_done and arb_lost are pulses that arrive only while a grant is held. Pulses while idle are ignored.
module can_txq_grant_ctrl
    import can_txq_pkg::*;
#(
    parameter int NUM_BUF = 3,
    localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               any_req,
    input  logic [IDX_W-1:0]   sel_idx,
    input  logic               sof_ready,
    input  logic               frame_done,
    input  logic               arb_lost,
    output logic               grant_valid,
    output logic [IDX_W-1:0]   grant_idx,
    output logic [NUM_BUF-1:0] clr_vec
);

    txq_state_e state_q;

    // Purpose: move between idle and busy, latching the winner on entry to busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= TXQ_IDLE;
            grant_idx <= '0;
        end else begin
            unique case (state_q)
                TXQ_IDLE: if (sof_ready && any_req) begin
                    state_q   <= TXQ_BUSY;
                    grant_idx <= sel_idx;
                end
                TXQ_BUSY: if (frame_done || arb_lost)
                    state_q <= TXQ_IDLE;
                default: state_q <= TXQ_IDLE;
            endcase
        end
    end

    // Purpose: the grant is presented for exactly the busy interval.
    always_comb grant_valid = (state_q == TXQ_BUSY);

    for (genvar i = 0; i < NUM_BUF; i++) begin : g_clr
        // Purpose: completion retires only the granted slot (it wins over arb_lost, R11).
        always_comb clr_vec[i] = grant_valid && frame_done && (grant_idx == IDX_W'(i));
    end

    // The grant is frozen until a frame-end pulse (R6).
    assert_grant_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !frame_done && !arb_lost) |=> (grant_valid && $stable(grant_idx)));

    // Without a pending flag, the start-of-frame sample grants nothing (R5).
    assert_no_idle_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && !any_req) |=> !grant_valid);

    // Either end pulse releases the grant (R7, R8).
    assert_end_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && (frame_done || arb_lost)) |=> !grant_valid);

endmodule

// File: rtl/can_txq_arbiter.sv
// Module: top of the transmit slot arbiter.
// What it does: ties the pending-flag bank, the winner search and the grant controller together.
// Assumes: the priority inputs are quasi-static configuration. They are sampled only at the start-of-frame point.
module can_txq_arbiter #(
    parameter int NUM_BUF = 3,
    parameter int PRIO_W  = 2,
    localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_BUF-1:0]        req_set,
    input  logic [NUM_BUF*PRIO_W-1:0] prio_flat,
    input  logic                      sof_ready,
    input  logic                      frame_done,
    input  logic                      arb_lost,
    output logic                      grant_valid,
    output logic [IDX_W-1:0]          grant_idx,
    output logic [NUM_BUF-1:0]        req_pending
);

    logic               any_req;
    logic [IDX_W-1:0]   sel_idx;
    logic [NUM_BUF-1:0] clr_vec;

    can_txq_req_flags #(.NUM_BUF(NUM_BUF)) flags_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (req_set),
        .clr_vec (clr_vec),
        .flags   (req_pending)
    );

    can_txq_select #(.NUM_BUF(NUM_BUF), .PRIO_W(PRIO_W)) select_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req_pending),
        .prio_flat (prio_flat),
        .sel_any   (any_req),
        .sel_idx   (sel_idx)
    );

    can_txq_grant_ctrl #(.NUM_BUF(NUM_BUF)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .any_req     (any_req),
        .sel_idx     (sel_idx),
        .sof_ready   (sof_ready),
        .frame_done  (frame_done),
        .arb_lost    (arb_lost),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx),
        .clr_vec     (clr_vec)
    );

    // A held grant always points at a pending slot (R3).
    assert_grant_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> req_pending[grant_idx]);

    // Losing arbitration keeps the slot queued (R8).
    assert_lost_requeues_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && arb_lost && !frame_done) |=> req_pending[$past(grant_idx)]);

endmodule

// File: tb/can_txq_arbiter_tb_top.sv
// Bench: a table walk of selection and frame-end cases, then directed tests for reset and corner cases.
module can_txq_arbiter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] req_set;
    logic [5:0] prio_flat;
    logic       sof_ready, frame_done, arb_lost;
    logic       grant_valid;
    logic [1:0] grant_idx;
    logic [2:0] req_pending;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;  // 250 MHz

    can_txq_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .req_set(req_set), .prio_flat(prio_flat),
        .sof_ready(sof_ready), .frame_done(frame_done), .arb_lost(arb_lost),
        .grant_valid(grant_valid), .grant_idx(grant_idx), .req_pending(req_pending)
    );

    // Vector: {prio {p2,p1,p0}, set mask, end kind (1 done / 0 lost), exp valid, exp idx, exp pending after end}
    localparam int NVEC = 9;
    localparam logic [15:0] VEC [NVEC] = '{
        {2'd0, 2'd0, 2'd1, 3'b001, 1'b1, 1'b1, 2'd0, 3'b000},  // single slot, done
        {2'd2, 2'd1, 2'd3, 3'b111, 1'b0, 1'b1, 2'd0, 3'b111},  // slot0 top, lost
        {2'd2, 2'd3, 2'd1, 3'b111, 1'b1, 1'b1, 2'd1, 3'b101},  // slot1 top, done
        {2'd2, 2'd2, 2'd2, 3'b111, 1'b1, 1'b1, 2'd2, 3'b011},  // three-way tie
        {2'd3, 2'd3, 2'd3, 3'b011, 1'b1, 1'b1, 2'd1, 3'b001},  // tie, slot2 idle
        {2'd2, 2'd3, 2'd2, 3'b101, 1'b0, 1'b1, 2'd2, 3'b101},  // tie, top prio not pending
        {2'd3, 2'd3, 2'd3, 3'b000, 1'b1, 1'b0, 2'd0, 3'b000},  // nothing pending
        {2'd0, 2'd0, 2'd3, 3'b110, 1'b1, 1'b1, 2'd2, 3'b010},  // tie at lowest level
        {2'd0, 2'd1, 2'd3, 3'b101, 1'b1, 1'b1, 2'd0, 3'b100}   // low index wins on value
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_set = '0; sof_ready = 1'b0; frame_done = 1'b0; arb_lost = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic pulse(input logic [2:0] set, input logic sof, input logic done, input logic lost);
        req_set = set; sof_ready = sof; frame_done = done; arb_lost = lost;
        step();
        req_set = '0; sof_ready = 1'b0; frame_done = 1'b0; arb_lost = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        prio_flat = '0;
        // Table walk: R3, R4, R5, R7, R8, R10 over distinct patterns.
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            prio_flat = VEC[v][15:10];
            pulse(VEC[v][9:7], 1'b0, 1'b0, 1'b0);
            pulse(3'b000, 1'b1, 1'b0, 1'b0);
            chk("R3/R4/R5 valid", int'(grant_valid), int'(VEC[v][5]));
            if (VEC[v][5]) chk("R3/R4 idx", int'(grant_idx), int'(VEC[v][4:3]));
            pulse(3'b000, 1'b0, VEC[v][6], !VEC[v][6]);
            chk("R7/R8 release", int'(grant_valid), 0);
            chk("R7/R8/R10 pending", int'(req_pending), int'(VEC[v][2:0]));
        end

        // R1: reset state.
        do_reset();
        chk("R1 valid", int'(grant_valid), 0);
        chk("R1 idx", int'(grant_idx), 0);
        chk("R1 pending", int'(req_pending), 0);

        // R5: start-of-frame with nothing pending.
        pulse(3'b000, 1'b1, 1'b0, 1'b0);
        chk("R5 valid", int'(grant_valid), 0);

        // R2: a request raised with sof_ready is not yet granted.
        prio_flat = {2'd0, 2'd1, 2'd0};
        pulse(3'b010, 1'b1, 1'b0, 1'b0);
        chk("R2 pending", int'(req_pending), 3'b010);
        chk("R2 valid", int'(grant_valid), 0);
        pulse(3'b000, 1'b1, 1'b0, 1'b0);
        chk("R2 granted", int'(grant_valid), 1);
        chk("R2 idx", int'(grant_idx), 1);

        // R6: disturbances during a frame leave the grant alone.
        prio_flat = {2'd0, 2'd0, 2'd3};
        pulse(3'b001, 1'b1, 1'b0, 1'b0);
        step(); step();
        chk("R6 valid", int'(grant_valid), 1);
        chk("R6 idx", int'(grant_idx), 1);

        // R9: re-request of the granted slot together with completion.
        pulse(3'b010, 1'b0, 1'b1, 1'b0);
        chk("R9 valid", int'(grant_valid), 0);
        chk("R9 pending", int'(req_pending), 3'b011);

        // R8: lost arbitration re-queues, and the next selection uses new priorities.
        pulse(3'b000, 1'b1, 1'b0, 1'b0);
        chk("R8 first idx", int'(grant_idx), 0);
        pulse(3'b000, 1'b0, 1'b0, 1'b1);
        chk("R8 pending", int'(req_pending), 3'b011);
        prio_flat = {2'd0, 2'd3, 2'd0};
        pulse(3'b000, 1'b1, 1'b0, 1'b0);
        chk("R8 reselect idx", int'(grant_idx), 1);

        // R11: completion wins over simultaneous lost arbitration.
        pulse(3'b000, 1'b0, 1'b1, 1'b1);
        chk("R11 valid", int'(grant_valid), 0);
        chk("R11 pending", int'(req_pending), 3'b001);

        // R10: stray end pulses while idle.
        pulse(3'b000, 1'b0, 1'b1, 1'b0);
        chk("R10 done idle", int'(req_pending), 3'b001);
        pulse(3'b000, 1'b0, 1'b0, 1'b1);
        chk("R10 lost idle", int'(req_pending), 3'b001);
        chk("R10 valid", int'(grant_valid), 0);

        // R1: reset in the middle of a frame.
        pulse(3'b000, 1'b1, 1'b0, 1'b0);
        chk("R1 pre-reset grant", int'(grant_valid), 1);
        do_reset();
        chk("R1 mid-frame valid", int'(grant_valid), 0);
        chk("R1 mid-frame pending", int'(req_pending), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule